// File: doc/BRIEF.md
# Streaming Reed-Solomon Product Encoder

The block encodes a two-dimensional Reed-Solomon product code with 31-symbol rows and columns and 29 information symbols per row and column, over GF(32). Information arrives one column of the 29x29 information matrix per accepted clock, as 29 five-bit symbols on a flat 145-bit bus. Every row has its own small feedback shift-register encoder, and all of them update in parallel. Whatever column the row encoders present in a cycle, whether an information column or one of the two row-parity columns, goes through a single combinational column encoder. That column encoder is a constant-coefficient XOR network that adds the two column-parity symbols.

The encoded matrix leaves as 31 coded columns of 155 bits, one per clock. There is no matrix storage between the row dimension and the column dimension, so each coded column appears one clock after the column that produced it. After the 29th information column, the block shifts the row parities out on two clocks of its own and refuses input during those two clocks. The source therefore delivers 29 columns in every 31 clocks.

Top module: `rs_product_encoder`

## Requirements
- R1: `in_ready` is high while information columns are expected. After the 29th accepted column of a matrix it is low for exactly two clocks, then high again.
- R2: An accepted column shows up one clock later on `out_data` with `out_valid` high. Rows 0..28 of that output equal the input symbols unchanged. Row r sits at bits [5r+4:5r] on both buses.
- R3: `out_sop` is high only together with `out_valid`, and only on the first coded column of each matrix.
- R4: Each of the 31 rows of a finished matrix is a codeword, with the information symbols first and the two parity symbols as output columns 30 and 31. A row is the polynomial whose first symbol is the coefficient of x^30, and it has zero syndromes at alpha and alpha^2. The field polynomial is x^5+x^2+1 and alpha = 5'b00010, so the generator is x^2 + 6x + 8.
- R5: Every coded column, the two row-parity columns included, is a codeword of the same code. Output rows 29 and 30 hold the parity for x^1 and x^0.
- R6: Input presented while `in_ready` is low is ignored. It does not change the output, the row state or the next matrix.
- R7: A clock with `in_ready` high and `in_valid` low produces no output column and leaves the matrix in progress intact.
- R8: During and right after reset, `in_ready` is 1 and `out_valid` and `out_sop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An information column is presented |
| in_data | input | 145 | 29 information symbols, row r at [5r+4:5r] |
| in_ready | output | 1 | The block takes an information column this clock |
| out_valid | output | 1 | A coded column is on out_data |
| out_sop | output | 1 | First coded column of a matrix |
| out_data | output | 155 | 31 coded symbols, row r at [5r+4:5r] |

## Verification
The hardest case to reach is a row-parity phase that starts while the source is still pushing data, combined with stalls that fall in the middle of a matrix. Both can corrupt the row state without disturbing the systematic symbols. The stimulus mixes stall-free matrices with matrices that stall at random, and it drives random junk with `in_valid` high during every two-clock parity gap. Directed matrices hold a single nonzero symbol in each extreme corner, or are all zeros or all ones. These show whether each row and column parity weight lands on the right symbol position.

// File: rtl/rs_product_encoder.sv
module rs_product_encoder #(
  parameter int SYM_W = 5,
  parameter int K = 29,
  parameter logic [SYM_W-1:0] PRIM_LOW = 5'b00101
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [K*SYM_W-1:0]   in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 out_sop,
  output logic [(K+2)*SYM_W-1:0] out_data
);
  localparam int N = K + 2;
  localparam int W = SYM_W;
  localparam int CW = $clog2(N);

  function automatic logic [W-1:0] gf_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] p;
    logic [W-1:0] x;
    p = '0;
    x = a;
    for (int k = 0; k < W; k++) begin
      if (b[k]) p = p ^ x;
      x = x[W-1] ? ((x << 1) ^ PRIM_LOW) : (x << 1);
    end
    return p;
  endfunction

  localparam logic [W-1:0] ALPHA1 = W'(2);
  localparam logic [W-1:0] ALPHA2 = gf_mul(ALPHA1, ALPHA1);
  localparam logic [W-1:0] G1 = ALPHA1 ^ ALPHA2;
  localparam logic [W-1:0] G0 = gf_mul(ALPHA1, ALPHA2);

  function automatic logic [2*W-1:0] col_coef(input int idx);
    logic [W-1:0] a1, a0, f, n1;
    a1 = '0;
    a0 = '0;
    for (int k = 0; k < K; k++) begin
      f = a1 ^ ((k == idx) ? W'(1) : W'(0));
      n1 = a0 ^ gf_mul(f, G1);
      a0 = gf_mul(f, G0);
      a1 = n1;
    end
    return {a1, a0};
  endfunction

  function automatic logic col_clean(input logic [N*W-1:0] v);
    logic [W-1:0] s1, s2;
    s1 = '0;
    s2 = '0;
    for (int j = 0; j < N; j++) begin
      s1 = gf_mul(s1, ALPHA1) ^ v[j*W +: W];
      s2 = gf_mul(s2, ALPHA2) ^ v[j*W +: W];
    end
    return (s1 == '0) && (s2 == '0);
  endfunction

  logic [CW-1:0] col;
  logic [W-1:0] hi [K];
  logic [W-1:0] lo [K];
  logic [K*W-1:0] slice;
  logic [2*W-1:0] term [K];
  logic [2*W-1:0] par;

  wire park = (col >= CW'(K));
  wire take = in_valid && !park;
  wire advance = take || park;
  assign in_ready = !park;

  always_ff @(posedge clk) begin
    if (rst) col <= '0;
    else if (advance) col <= (col == CW'(N-1)) ? '0 : col + 1'b1;
  end

  for (genvar i = 0; i < K; i++) begin : g_row
    localparam logic [2*W-1:0] CC = col_coef(i);
    wire [W-1:0] din = in_data[i*W +: W];
    wire [W-1:0] fb = din ^ hi[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        hi[i] <= '0;
        lo[i] <= '0;
      end else if (take) begin
        hi[i] <= lo[i] ^ gf_mul(fb, G1);
        lo[i] <= gf_mul(fb, G0);
      end else if (park) begin
        hi[i] <= lo[i];
        lo[i] <= '0;
      end
    end

    assign slice[i*W +: W] = park ? hi[i] : din;
    assign term[i] = {gf_mul(slice[i*W +: W], CC[2*W-1:W]), gf_mul(slice[i*W +: W], CC[W-1:0])};
  end

  always_comb begin
    par = '0;
    for (int i = 0; i < K; i++) par = par ^ term[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop <= 1'b0;
      out_data <= '0;
    end else begin
      out_valid <= advance;
      out_sop <= take && (col == '0);
      if (advance) out_data <= {par[W-1:0], par[2*W-1:W], slice};
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  a_r2_systematic: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_data[K*W-1:0] == $past(in_data)));
  a_r1_gap_two: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |=> !in_ready);
  a_r1_gap_end: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && $past(!in_ready)) |=> in_ready);
  a_r1_parity_out: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid);
  a_r7_stall: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !out_valid);
  a_r3_sop: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid);
  a_r5_col_syndrome: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> col_clean(out_data));
endmodule

// File: tb/sim_rs_product_encoder.sv
module sim_rs_product_encoder;
  localparam int NMAT = 24;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [144:0] in_data = '0;
  logic in_ready, out_valid, out_sop;
  logic [154:0] out_data;

  always #5 clk = ~clk;

  rs_product_encoder u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data));

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [4:0] info [NMAT][29][29];
  logic [4:0] em [31][31];
  logic [154:0] got [31];
  int mcol = 0;
  int mon_mat = 0;
  int low_run = 0;
  bit done = 0;

  function automatic logic [4:0] bmul(input logic [4:0] a, input logic [4:0] b);
    logic [4:0] acc = '0;
    for (int k = 4; k >= 0; k--) begin
      acc = acc[4] ? ((acc << 1) ^ 5'b00101) : (acc << 1);
      if (b[k]) acc = acc ^ a;
    end
    return acc;
  endfunction

  task automatic div_par(inout logic [4:0] v [31]);
    logic [4:0] w [31];
    w = v;
    for (int t = 0; t < 29; t++) begin
      w[t+1] = w[t+1] ^ bmul(w[t], 5'd6);
      w[t+2] = w[t+2] ^ bmul(w[t], 5'd8);
    end
    v[29] = w[29];
    v[30] = w[30];
  endtask

  task automatic build_exp(input int m);
    logic [4:0] v [31];
    for (int r = 0; r < 29; r++) begin
      for (int j = 0; j < 31; j++) v[j] = (j < 29) ? info[m][r][j] : 5'd0;
      div_par(v);
      for (int j = 0; j < 31; j++) em[r][j] = v[j];
    end
    for (int j = 0; j < 31; j++) begin
      for (int i = 0; i < 31; i++) v[i] = (i < 29) ? em[i][j] : 5'd0;
      div_par(v);
      em[29][j] = v[29];
      em[30][j] = v[30];
    end
  endtask

  function automatic bit syn_ok(input logic [4:0] v [31]);
    logic [4:0] s1 = '0, s2 = '0;
    for (int j = 0; j < 31; j++) begin
      s1 = bmul(s1, 5'd2) ^ v[j];
      s2 = bmul(s2, 5'd4) ^ v[j];
    end
    return (s1 == 0) && (s2 == 0);
  endfunction

  task automatic compare_matrix();
    logic [154:0] e;
    logic [4:0] v [31];
    bit ok;
    build_exp(mon_mat);
    for (int j = 0; j < 31; j++) begin
      for (int r = 0; r < 31; r++) e[r*5 +: 5] = em[r][j];
      checks++;
      if (got[j] !== e) begin
        fails++;
        $display("FAIL R2/R4/R5/R6 matrix %0d col %0d: got %h expected %h", mon_mat, j, got[j], e);
      end
    end
    ok = 1;
    for (int r = 0; r < 31; r++) begin
      for (int j = 0; j < 31; j++) v[j] = got[j][r*5 +: 5];
      if (!syn_ok(v)) ok = 0;
    end
    checks++;
    if (!ok) begin fails++; $display("FAIL R4 matrix %0d row syndromes: got nonzero expected zero", mon_mat); end
    ok = 1;
    for (int j = 0; j < 31; j++) begin
      for (int r = 0; r < 31; r++) v[r] = got[j][r*5 +: 5];
      if (!syn_ok(v)) ok = 0;
    end
    checks++;
    if (!ok) begin fails++; $display("FAIL R5 matrix %0d column syndromes: got nonzero expected zero", mon_mat); end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (!in_ready) low_run++;
      else if (low_run != 0) begin
        checks++;
        if (low_run != 2) begin fails++; $display("FAIL R1 ready gap: got %0d expected 2", low_run); end
        low_run = 0;
      end
      if (out_valid) begin
        checks++;
        if (out_sop !== (mcol == 0)) begin
          fails++;
          $display("FAIL R3 sop at col %0d: got %b expected %b", mcol, out_sop, mcol == 0);
        end
        got[mcol] = out_data;
        mcol++;
        if (mcol == 31) begin
          if (mon_mat < NMAT) compare_matrix();
          mon_mat++;
          mcol = 0;
        end
      end else if (out_sop) begin
        checks++; fails++;
        $display("FAIL R3 sop without valid: got 1 expected 0");
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic send_matrix(input int m, input int stall_pct);
    int c = 0;
    bit stalled = 0;
    while (c < 29) begin
      @(posedge clk); #1;
      if (stalled) begin
        checks++;
        if (out_valid !== 1'b0) begin fails++; $display("FAIL R7 stall produced output: got %b expected 0", out_valid); end
      end
      stalled = 0;
      if (!in_ready) begin
        in_valid = 1;
        for (int r = 0; r < 29; r++) in_data[r*5 +: 5] = 5'($urandom_range(31));
      end else if (int'($urandom_range(99)) < stall_pct) begin
        in_valid = 0;
        for (int r = 0; r < 29; r++) in_data[r*5 +: 5] = 5'($urandom_range(31));
        stalled = 1;
      end else begin
        in_valid = 1;
        for (int r = 0; r < 29; r++) in_data[r*5 +: 5] = info[m][r][c];
        c++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int m = 0; m < NMAT; m++)
      for (int r = 0; r < 29; r++)
        for (int j = 0; j < 29; j++)
          case (m)
            0: info[m][r][j] = 5'd0;
            1: info[m][r][j] = 5'd31;
            2: info[m][r][j] = (r == 0 && j == 0) ? 5'd1 : 5'd0;
            3: info[m][r][j] = (r == 28 && j == 28) ? 5'd19 : 5'd0;
            4: info[m][r][j] = (j == 0) ? 5'($urandom_range(31)) : 5'd0;
            default: info[m][r][j] = 5'($urandom_range(31));
          endcase
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (in_ready !== 1 || out_valid !== 0 || out_sop !== 0) begin
      fails++; $display("FAIL R8 in reset: got %b%b%b expected 100", in_ready, out_valid, out_sop);
    end
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    checks++;
    if (in_ready !== 1 || out_valid !== 0 || out_sop !== 0) begin
      fails++; $display("FAIL R8 after reset: got %b%b%b expected 100", in_ready, out_valid, out_sop);
    end
    for (int m = 0; m < NMAT; m++) send_matrix(m, (m < 6 || m % 3 == 0) ? 0 : 30);
    @(posedge clk); #1 in_valid = 0;
    for (int k = 0; k < 2000 && mon_mat < NMAT; k++) @(posedge clk);
    repeat (4) @(posedge clk);
    checks++;
    if (mon_mat != NMAT) begin fails++; $display("FAIL R2 matrices out: got %0d expected %0d", mon_mat, NMAT); end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule